// File: doc/BRIEF.md
# Ethernet transmit status tracker

This block follows a single packet through its half-duplex transmit attempt and builds the ten-bit status word that a MAC hands back once the packet is finished. It watches a packet-start strobe, a strobe for each byte put on the wire, a collision strobe, a carrier-busy (defer) level, a bit-time tick, a deferral-check enable and a transmit-done strobe. From these it counts collisions, measures how long the medium held the packet off, and decides whether the attempt ends normally or is cut short.

The attempt can end in four ways: a collision after the late-collision window, the collision limit, a deferral that lasts too long while deferral checking is enabled, or the transmit-done strobe. The first of these to occur ends the attempt. The block then raises a single-cycle valid pulse, freezes the status word, and ignores all further events until the next packet start. Backoff timing, the data path and any register access belong to the surrounding MAC.

Top module: `txst_tracker`

## Requirements
- R1: The status word has this layout: bit 9 is late collision, bit 8 is excessive collisions, bits 6:3 are the collision count, bit 2 is excessive deferral, and bit 0 is deferred. Bits 7 and 1 always read zero.
- R2: A collision sampled after 64 bytes have already been sent ends the attempt and sets bit 9. A collision sampled after only 63 bytes does not.
- R3: Every collision sampled during the attempt increments the count in bits 6:3. The count saturates at 15.
- R4: The 16th collision of a packet ends the attempt and sets bit 8. The count stays at 15.
- R5: Bit 0 is set if carrier-busy is seen in any cycle of the attempt before the first byte is sent. Carrier-busy after the first byte has no effect.
- R6: Bit-time ticks that arrive while carrier-busy is high and before the first byte is sent advance a deferral timer. When the enable is high and the timer exceeds 24288, the attempt ends and bit 2 is set. A timer of exactly 24288 does not end the attempt.
- R7: While the deferral-check enable is low, no deferral length ends the attempt or sets bit 2.
- R8: Status-valid is high for exactly one cycle. It appears after the clock edge that samples either transmit-done or the first abort condition, whichever comes first, and at that point the status word holds the final value.
- R9: After status-valid, collisions, bytes, deferral and transmit-done have no effect until the next packet start. The status word holds its value and no second valid pulse appears.
- R10: After reset, status-valid and the status word are zero, and events are ignored until a packet start. A packet start clears all counters and flags, so the word reads zero after the edge that samples it. Packet start takes priority over every other input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start of a new packet; clears all tracking |
| byte_sent | input | 1 | One byte of the packet went out this cycle |
| coll | input | 1 | Collision detected this cycle |
| carrier_busy | input | 1 | Medium busy; transmission held off |
| bit_tick | input | 1 | One bit time elapsed |
| defer_chk_en | input | 1 | Enables the excessive-deferral abort |
| tx_done | input | 1 | Transmission completed |
| status_word | output | 10 | Packet status word (layout in R1) |
| stat_valid | output | 1 | One-cycle pulse marking the final status |

## Verification
The bench checks both sides of each threshold. It sends collisions after 63 and after 64 bytes. It drives 15 and 16 collisions. It runs deferrals of exactly 24288 ticks and of 24289 ticks, and a long deferral with checking disabled. A design with an off-by-one window or limit would abort one step early or one step late. A counter that wraps would report a count of 0 with bit 8 set. A timer compared with greater-or-equal would abort at 24288.

After an abort, the bench sends more collisions and a transmit-done. A design that kept listening would emit a second valid pulse or change the frozen word. The bench also drives carrier-busy after the first byte, which must not mark the packet as deferred. Finally, it checks that a packet start wipes a flagged word.

// File: rtl/txst_pkg.sv
package txst_pkg;

    localparam int LATE_WIN_BYTES = 64;
    localparam int COLL_ABORT_AT  = 16;
    localparam int DEFER_BIT_MAX  = 24288;
    localparam int CNT_W          = 4;
    localparam int STAT_W         = 10;

    typedef struct packed {
        logic             late;
        logic             xcoll;
        logic             rsv_hi;
        logic [CNT_W-1:0] cnt;
        logic             xdef;
        logic             rsv_lo;
        logic             dfr;
    } txst_word_t;

    function automatic txst_word_t txst_pack(
        input logic             late,
        input logic             xcoll,
        input logic [CNT_W-1:0] cnt,
        input logic             xdef,
        input logic             dfr
    );
        txst_word_t w;
        w.late   = late;
        w.xcoll  = xcoll;
        w.rsv_hi = 1'b0;
        w.cnt    = cnt;
        w.xdef   = xdef;
        w.rsv_lo = 1'b0;
        w.dfr    = dfr;
        return w;
    endfunction

endpackage

// File: rtl/txst_coll_track.sv
module txst_coll_track
    import txst_pkg::*;
#(
    parameter int LATE_BYTES = LATE_WIN_BYTES,
    parameter int COLL_LIMIT = COLL_ABORT_AT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             live,
    input  logic             byte_sent,
    input  logic             coll,
    output logic [CNT_W-1:0] cnt_o,
    output logic             late_o,
    output logic             xcoll_o,
    output logic             late_hit_o,
    output logic             xcoll_hit_o,
    output logic             started_o
);
    localparam int BC_W    = $clog2(LATE_BYTES + 1);
    localparam int CT_W    = $clog2(COLL_LIMIT + 1);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [BC_W-1:0] bytes_q;
    logic [CT_W-1:0] total_q;
    logic            late_q, xcoll_q;
    logic            bytes_full;

    assign bytes_full  = (bytes_q == BC_W'(LATE_BYTES));
    assign late_hit_o  = live && coll && bytes_full;
    assign xcoll_hit_o = live && coll && (total_q == CT_W'(COLL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bytes_q <= '0;
            total_q <= '0;
            late_q  <= 1'b0;
            xcoll_q <= 1'b0;
        end else if (live) begin
            if (byte_sent && !bytes_full)
                bytes_q <= bytes_q + 1'b1;
            if (coll && total_q != CT_W'(COLL_LIMIT))
                total_q <= total_q + 1'b1;
            if (late_hit_o)
                late_q <= 1'b1;
            if (xcoll_hit_o)
                xcoll_q <= 1'b1;
        end
    end

    assign cnt_o     = (total_q > CT_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : CNT_W'(total_q);
    assign late_o    = late_q;
    assign xcoll_o   = xcoll_q;
    assign started_o = (bytes_q != '0);

    // R3
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_W'(CNT_MAX) && live && coll && !clr) |=> (cnt_o == CNT_W'(CNT_MAX)));

    // R4
    xcoll_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xcoll_q) |-> (cnt_o == CNT_W'(CNT_MAX)));

    // R2
    late_win_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(late_q) |-> $past(started_o));

endmodule

// File: rtl/txst_defer_track.sv
module txst_defer_track
    import txst_pkg::*;
#(
    parameter int DEFER_MAX = DEFER_BIT_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic live,
    input  logic started,
    input  logic busy,
    input  logic tick,
    input  logic chk_en,
    output logic dfr_o,
    output logic xdef_o,
    output logic xdef_hit_o
);
    localparam int TM_W = $clog2(DEFER_MAX + 2);

    logic [TM_W-1:0] timer_q, timer_nxt;
    logic            dfr_q, xdef_q;
    logic            waiting;

    assign waiting = live && !started && busy;

    always_comb begin
        timer_nxt = timer_q;
        if (waiting && tick && timer_q <= TM_W'(DEFER_MAX))
            timer_nxt = timer_q + 1'b1;
    end

    assign xdef_hit_o = live && chk_en && (timer_nxt > TM_W'(DEFER_MAX));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            timer_q <= '0;
            dfr_q   <= 1'b0;
            xdef_q  <= 1'b0;
        end else if (live) begin
            timer_q <= timer_nxt;
            if (waiting)
                dfr_q <= 1'b1;
            if (xdef_hit_o)
                xdef_q <= 1'b1;
        end
    end

    assign dfr_o  = dfr_q;
    assign xdef_o = xdef_q;

    // R7
    xdef_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xdef_q) |-> $past(chk_en));

    // R5
    xdef_dfr_chk: assert property (@(posedge clk) disable iff (rst)
        xdef_q |-> dfr_q);

endmodule

// File: rtl/txst_tracker.sv
module txst_tracker
    import txst_pkg::*;
#(
    parameter int LATE_BYTES = LATE_WIN_BYTES,
    parameter int COLL_LIMIT = COLL_ABORT_AT,
    parameter int DEFER_MAX  = DEFER_BIT_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic              byte_sent,
    input  logic              coll,
    input  logic              carrier_busy,
    input  logic              bit_tick,
    input  logic              defer_chk_en,
    input  logic              tx_done,
    output logic [STAT_W-1:0] status_word,
    output logic              stat_valid
);
    logic             active_q, valid_q, live, end_evt;
    logic [CNT_W-1:0] cnt;
    logic             late, xcoll, late_hit, xcoll_hit, started;
    logic             dfr, xdef, xdef_hit;
    txst_word_t       word;

    assign live = active_q && !pkt_start;

    txst_coll_track #(
        .LATE_BYTES(LATE_BYTES),
        .COLL_LIMIT(COLL_LIMIT)
    ) coll_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (pkt_start),
        .live       (live),
        .byte_sent  (byte_sent),
        .coll       (coll),
        .cnt_o      (cnt),
        .late_o     (late),
        .xcoll_o    (xcoll),
        .late_hit_o (late_hit),
        .xcoll_hit_o(xcoll_hit),
        .started_o  (started)
    );

    txst_defer_track #(
        .DEFER_MAX(DEFER_MAX)
    ) defer_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (pkt_start),
        .live      (live),
        .started   (started),
        .busy      (carrier_busy),
        .tick      (bit_tick),
        .chk_en    (defer_chk_en),
        .dfr_o     (dfr),
        .xdef_o    (xdef),
        .xdef_hit_o(xdef_hit)
    );

    assign end_evt = live && (tx_done || late_hit || xcoll_hit || xdef_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= end_evt;
            if (pkt_start)
                active_q <= 1'b1;
            else if (end_evt)
                active_q <= 1'b0;
        end
    end

    assign word        = txst_pack(late, xcoll, cnt, xdef, dfr);
    assign status_word = word;
    assign stat_valid  = valid_q;

    // R8
    pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    // R8
    done_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && tx_done && !pkt_start) |=> stat_valid);

    // R9
    frozen_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !pkt_start) |=> $stable(status_word));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> (status_word == '0 && !stat_valid));

endmodule

// File: tb/txst_tracker_tb_top.sv
module txst_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pkt_start = 0, byte_sent = 0, coll = 0, carrier_busy = 0;
    logic       bit_tick = 0, defer_chk_en = 0, tx_done = 0;
    logic [9:0] status_word;
    logic       stat_valid;

    int n_run = 0;
    int n_fail = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic       prev_valid = 1'b0;

    always #5 clk = ~clk;

    txst_tracker dut_i (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .byte_sent(byte_sent),
        .coll(coll), .carrier_busy(carrier_busy), .bit_tick(bit_tick),
        .defer_chk_en(defer_chk_en), .tx_done(tx_done),
        .status_word(status_word), .stat_valid(stat_valid)
    );

    function automatic logic [9:0] mk(input logic lt, input logic xc,
                                      input int c, input logic xd, input logic df);
        return {lt, xc, 1'b0, 4'(c), xd, 1'b0, df};
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input logic [9:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start_pkt();
        pkt_start = 1; step(); pkt_start = 0;
    endtask
    task automatic send(input int n);
        byte_sent = 1; repeat (n) step(); byte_sent = 0;
    endtask
    task automatic collide(input int n);
        coll = 1; repeat (n) step(); coll = 0;
    endtask
    task automatic hold_off(input int n);
        carrier_busy = 1; bit_tick = 1; repeat (n) step();
        carrier_busy = 0; bit_tick = 0;
    endtask
    task automatic finish_tx();
        tx_done = 1; step(); tx_done = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) step();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (stat_valid) begin
                n_run++;
                if (prev_valid) begin
                    n_fail++;
                    $display("FAIL R8: actual valid width 2 expected 1");
                end
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: actual unexpected valid word %03h expected none", status_word);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(status_word, e, t);
                    check({8'b0, status_word[7], status_word[1]}, 10'h000, "R1 reserved bits");
                end
            end
            prev_valid <= stat_valid;
        end
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R10 reset state
        check({status_word[9:1], stat_valid}, 10'h000, "R10 reset state");
        collide(2); finish_tx(); idle(2);
        check(status_word, 10'h000, "R10 ignored before start");

        // clean packet, R8
        start_pkt(); send(100);
        expect_word(mk(0, 0, 0, 0, 0), "R8 clean done");
        finish_tx(); idle(3);

        // R3 three collisions
        start_pkt(); send(10); collide(3); send(50);
        expect_word(mk(0, 0, 3, 0, 0), "R3 count three");
        finish_tx(); idle(3);

        // R2 collision after 63 bytes is not late
        start_pkt(); send(63); collide(1); send(5);
        expect_word(mk(0, 0, 1, 0, 0), "R2 boundary 63");
        finish_tx(); idle(3);

        // R2 late collision, then R9 ignore further events
        start_pkt(); send(64);
        expect_word(mk(1, 0, 1, 0, 0), "R2 late abort");
        collide(1);
        collide(2); send(3); hold_off(4); finish_tx(); idle(3);
        check(status_word, mk(1, 0, 1, 0, 0), "R9 frozen after abort");

        // R3 fifteen collisions saturate-free
        start_pkt(); collide(15); send(20);
        expect_word(mk(0, 0, 15, 0, 0), "R3 count fifteen");
        finish_tx(); idle(3);

        // R4 sixteenth collision
        start_pkt();
        expect_word(mk(0, 1, 15, 0, 0), "R4 excessive collisions");
        collide(16); idle(3);
        check(status_word, mk(0, 1, 15, 0, 0), "R4 count held at 15");

        // R10 start clears a flagged word
        start_pkt();
        check(status_word, 10'h000, "R10 start clears");
        // R5 short deferral
        defer_chk_en = 1;
        hold_off(5); send(20);
        expect_word(mk(0, 0, 0, 0, 1), "R5 deferred");
        finish_tx(); idle(3);

        // R5 busy after first byte does not count
        start_pkt(); send(5); hold_off(10); send(5);
        expect_word(mk(0, 0, 0, 0, 0), "R5 busy after start");
        finish_tx(); idle(3);

        // R6 exactly at limit: no abort
        start_pkt(); hold_off(24288); idle(2);
        check({9'b0, stat_valid}, 10'h000, "R6 no abort at 24288");
        send(10);
        expect_word(mk(0, 0, 0, 0, 1), "R6 at limit done");
        finish_tx(); idle(3);

        // R6 one past the limit aborts
        start_pkt();
        expect_word(mk(0, 0, 0, 1, 1), "R6 excessive deferral");
        hold_off(24289); idle(3);

        // R7 enable low
        defer_chk_en = 0;
        start_pkt(); hold_off(24300); send(4);
        expect_word(mk(0, 0, 0, 0, 1), "R7 check disabled");
        finish_tx(); idle(3);

        // R10 start priority over done in same cycle
        pkt_start = 1; tx_done = 1; step(); pkt_start = 0; tx_done = 0;
        idle(2);
        check({9'b0, stat_valid}, 10'h000, "R10 start beats done");
        expect_word(mk(0, 0, 0, 0, 0), "R10 after priority");
        finish_tx(); idle(3);

        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R8: actual %0d words missing expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule